// File: doc/BRIEF.md
# Clock divider and frame-trigger unit

This unit runs on the incoming sample clock. It produces enables and square waves for a family of derived clocks: a full-rate qualifier, fixed divide-by-two and divide-by-four waves, a divide-by-N wave with N a power of two from 4 to 1024, and an enable for a core that always runs at half rate. A mode input sets how that core enable is made. In full-clock mode the incoming clock is halved, so the enable is high on every other cycle. In half-clock mode the incoming clock already runs at core rate, so the enable stays high.

The unit also emits a one-cycle word-frame trigger. Its period is either the length of one of nine pseudo-random sequences or a user value, and a downstream scope or checker uses it to lock onto a pattern. Requests for a new N or a new frame period are applied only at the end of the running period, so the outputs never carry a shortened phase. A synchronous reset restarts every counter together, so all derived waves and the trigger start from one common phase.

Top module: `clk_frame_gen`

## Requirements
- R1: `ref_en_o` is low while `rst_ni` is low and high from the first rising clock edge after `rst_ni` is released.
- R2: Counting cycles from the last sync reset (cycle 0), `div2_o` is high on even cycles and low on odd cycles.
- R3: `div4_o` is high on cycles 0 and 1 of every group of four and low on cycles 2 and 3.
- R4: `nsel_i` code k (0..8) selects N = 2^(k+2). Codes 9 to 15 select N = 1024. `divn_o` is high for the first N/2 cycles of each N-cycle period and low for the rest.
- R5: With `full_mode_i` = 0, `core_en_o` is always high. With `full_mode_i` = 1, it is high on even cycles and low on odd cycles. The mode is taken at each sync reset and at the end of every odd cycle.
- R6: `frame_o` is high for one cycle at the start of every frame period P. `frame_sel_i` codes 1 to 9 give P = 2^n - 1 with n = 7, 9, 10, 11, 13, 15, 20, 23, 31 respectively. Code 0 and codes 10 to 15 give P = `frame_len_i`, and values below 2 are raised to 2.
- R7: A new N is taken only in the last cycle of the running N period, and the next period starts with a full high half. No high or low phase of `divn_o` is shorter than 2 cycles.
- R8: A new frame period is taken only in the last cycle of the running frame period.
- R9: A sync reset (`srst_i` high at a rising edge) clears all counters and loads N, P and mode at once. In the cycle after it, `div2_o`, `div4_o`, `divn_o`, `frame_o` and `core_en_o` are all high.
- R10: After an asynchronous reset and before any sync reset, the unit runs with N = 4, P = 127 and half-clock mode, starting at cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | incoming clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| srst_i | input | 1 | synchronous reset, realigns all outputs |
| full_mode_i | input | 1 | 1: halve the clock for the core enable |
| nsel_i | input | SEL_W (4) | divide-by-N code |
| frame_sel_i | input | 4 | frame period source code |
| frame_len_i | input | FRAME_W (32) | user frame period in clock cycles |
| ref_en_o | output | 1 | full-rate qualifier |
| core_en_o | output | 1 | half-rate core enable |
| div2_o | output | 1 | clock divided by 2 |
| div4_o | output | 1 | clock divided by 4 |
| divn_o | output | 1 | clock divided by selected N |
| frame_o | output | 1 | word-frame trigger pulse |

## Verification
The assertions assume that `rst_ni` is low from time zero and that `srst_i` is synchronous and held across whole cycles. They also assume that every control input changes only between rising edges, so N, period and mode requests are seen stable at the edge that loads them. The stimulus changes inputs only on falling edges and holds the asynchronous reset from the start. It changes N and the frame period in mid-period, on odd and even cycles, so the deferred loading is exercised. Frame lengths of 0 and 1 are driven so that the assertions on the minimum period and the single-cycle pulse hold through the clamp.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic {
    CORE_DIRECT = 1'b0,
    CORE_HALVED = 1'b1
  } core_mode_e;

  localparam int unsigned DEF_FRAME_ORDER = 7;

  // sequence order for a preset frame code, 0 for user length
  function automatic int unsigned prbs_order(input logic [3:0] code);
    case (code)
      4'd1:    return 7;
      4'd2:    return 9;
      4'd3:    return 10;
      4'd4:    return 11;
      4'd5:    return 13;
      4'd6:    return 15;
      4'd7:    return 20;
      4'd8:    return 23;
      4'd9:    return 31;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/cdiv_fixed.sv
module cdiv_fixed
  import clkdiv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic full_mode_i,
  output logic ref_en_o,
  output logic core_en_o,
  output logic div2_o,
  output logic div4_o
);

  logic [1:0] cnt_q;
  core_mode_e mode_q;
  logic       ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= CORE_DIRECT;
      ref_q  <= 1'b0;
    end else begin
      ref_q <= 1'b1;
      if (srst_i) begin
        cnt_q  <= '0;
        mode_q <= core_mode_e'(full_mode_i);
      end else begin
        cnt_q <= cnt_q + 2'd1;
        // mode switches only at the end of a core cycle pair
        if (cnt_q[0]) mode_q <= core_mode_e'(full_mode_i);
      end
    end
  end

  assign ref_en_o  = ref_q;
  assign div2_o    = ~cnt_q[0];
  assign div4_o    = ~cnt_q[1];
  assign core_en_o = (mode_q == CORE_HALVED) ? ~cnt_q[0] : 1'b1;

  assert_core_alt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (mode_q == CORE_HALVED && core_en_o) |=> !core_en_o);

  assert_div4_on_div2_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div4_o) |-> div2_o);

  assert_div2_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    !div2_o |=> div2_o);

endmodule

// File: rtl/cdiv_sel.sv
module cdiv_sel #(
  parameter int unsigned MIN_LOG = 2,
  parameter int unsigned MAX_LOG = 10,
  parameter int unsigned SEL_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic [SEL_W-1:0] nsel_i,
  output logic             divn_o
);

  localparam int unsigned NCODES = MAX_LOG - MIN_LOG + 1;
  localparam int unsigned CW     = MAX_LOG;
  localparam logic [SEL_W-1:0] TOP_CODE = SEL_W'(NCODES - 1);

  logic [CW-1:0]     nc_q;
  logic [SEL_W-1:0]  code_q;
  logic [SEL_W-1:0]  code_req;
  logic [NCODES-1:0] term_v;
  logic [NCODES-1:0] hi_v;
  logic              term;

  assign code_req = (nsel_i > TOP_CODE) ? TOP_CODE : nsel_i;

  // one terminal-count and one phase tap per selectable ratio
  for (genvar k = 0; k < NCODES; k++) begin : g_ratio
    assign term_v[k] = &nc_q[k+MIN_LOG-1:0];
    assign hi_v[k]   = ~nc_q[k+MIN_LOG-1];
  end

  assign term   = term_v[code_q];
  assign divn_o = hi_v[code_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nc_q   <= '0;
      code_q <= '0;
    end else if (srst_i || term) begin
      nc_q   <= '0;
      code_q <= code_req;
    end else begin
      nc_q <= nc_q + CW'(1);
    end
  end

  assert_hi_min_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    $rose(divn_o) |=> divn_o);

  assert_lo_min_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    $fell(divn_o) |=> !divn_o);

  assert_sel_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_q) |-> $past(term || srst_i));

  assert_code_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= TOP_CODE);

endmodule

// File: rtl/cdiv_frame.sv
module cdiv_frame
  import clkdiv_pkg::*;
#(
  parameter int unsigned FW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic [3:0]    frame_sel_i,
  input  logic [FW-1:0] frame_len_i,
  output logic          frame_o
);

  localparam logic [FW-1:0] DEF_PERIOD = (FW'(1) << DEF_FRAME_ORDER) - FW'(1);
  localparam logic [FW-1:0] MIN_PERIOD = FW'(2);

  logic [FW-1:0] fc_q;
  logic [FW-1:0] per_q;
  logic [FW-1:0] per_req;
  int unsigned   ord;
  logic          term;

  always_comb begin
    ord = prbs_order(frame_sel_i);
    if (ord != 0)                       per_req = (FW'(1) << ord) - FW'(1);
    else if (frame_len_i < MIN_PERIOD)  per_req = MIN_PERIOD;
    else                                per_req = frame_len_i;
  end

  assign term    = (fc_q == per_q - FW'(1));
  assign frame_o = (fc_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fc_q  <= '0;
      per_q <= DEF_PERIOD;
    end else if (srst_i || term) begin
      fc_q  <= '0;
      per_q <= per_req;
    end else begin
      fc_q <= fc_q + FW'(1);
    end
  end

  assert_pulse_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    frame_o |=> !frame_o);

  assert_period_min_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q >= MIN_PERIOD);

  assert_per_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_q) |-> $past(term || srst_i));

endmodule

// File: rtl/clk_frame_gen.sv
module clk_frame_gen #(
  parameter int unsigned FRAME_W     = 32,
  parameter int unsigned DIV_MIN_LOG = 2,
  parameter int unsigned DIV_MAX_LOG = 10,
  parameter int unsigned SEL_W       = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               srst_i,
  input  logic               full_mode_i,
  input  logic [SEL_W-1:0]   nsel_i,
  input  logic [3:0]         frame_sel_i,
  input  logic [FRAME_W-1:0] frame_len_i,
  output logic               ref_en_o,
  output logic               core_en_o,
  output logic               div2_o,
  output logic               div4_o,
  output logic               divn_o,
  output logic               frame_o
);

  cdiv_fixed i_fixed (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .srst_i      (srst_i),
    .full_mode_i (full_mode_i),
    .ref_en_o    (ref_en_o),
    .core_en_o   (core_en_o),
    .div2_o      (div2_o),
    .div4_o      (div4_o)
  );

  cdiv_sel #(
    .MIN_LOG (DIV_MIN_LOG),
    .MAX_LOG (DIV_MAX_LOG),
    .SEL_W   (SEL_W)
  ) i_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (srst_i),
    .nsel_i (nsel_i),
    .divn_o (divn_o)
  );

  cdiv_frame #(
    .FW (FRAME_W)
  ) i_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .srst_i      (srst_i),
    .frame_sel_i (frame_sel_i),
    .frame_len_i (frame_len_i),
    .frame_o     (frame_o)
  );

  // selectable wave starts its period on a fixed-wave group boundary
  assert_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(divn_o) |-> (div2_o && div4_o));

  assert_reset_phase_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(srst_i) |-> (div2_o && div4_o && divn_o && frame_o && core_en_o));

endmodule

// File: tb/test_clk_frame_gen.sv
module test_clk_frame_gen;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        srst = 1'b0;
  logic        full = 1'b0;
  logic [3:0]  nsel = 4'd3;
  logic [3:0]  fsel = 4'd0;
  logic [31:0] flen = 32'd50;
  logic ref_en_o, core_en_o, div2_o, div4_o, divn_o, frame_o;

  int ntot = 0;
  int nbad = 0;
  string ctx = "R10";

  int     mk, mn, mnact;
  longint mf, mpact;
  bit     mfull, mref;

  always #2 clk = ~clk;

  clk_frame_gen i_clk_frame_gen (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .srst_i      (srst),
    .full_mode_i (full),
    .nsel_i      (nsel),
    .frame_sel_i (fsel),
    .frame_len_i (flen),
    .ref_en_o    (ref_en_o),
    .core_en_o   (core_en_o),
    .div2_o      (div2_o),
    .div4_o      (div4_o),
    .divn_o      (divn_o),
    .frame_o     (frame_o)
  );

  function automatic int nreq_f(input logic [3:0] s);
    return (s > 4'd8) ? 1024 : (4 << s);
  endfunction

  function automatic longint prd_f(input logic [3:0] s, input logic [31:0] l);
    case (s)
      4'd1: return 127;
      4'd2: return 511;
      4'd3: return 1023;
      4'd4: return 2047;
      4'd5: return 8191;
      4'd6: return 32767;
      4'd7: return (longint'(1) << 20) - 1;
      4'd8: return (longint'(1) << 23) - 1;
      4'd9: return (longint'(1) << 31) - 1;
      default: return (l < 2) ? 2 : longint'(l);
    endcase
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    ntot++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s (%s %s) act=%0d exp=%0d t=%0t", ctx, req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R1", "ref_en", ref_en_o, mref);
    chk("R2", "div2", div2_o, (mk % 2 == 0));
    chk("R3", "div4", div4_o, (mk % 4 < 2));
    chk("R4", "divn", divn_o, (mn < mnact / 2));
    chk("R6", "frame", frame_o, (mf == 0));
    chk("R5", "core_en", core_en_o, mfull ? (mk % 2 == 0) : 1);
  endtask

  // model advances at the edge from inputs set at the previous falling edge
  task automatic tick();
    @(posedge clk);
    mref = 1'b1;
    if (srst) begin
      mk = 0; mn = 0; mnact = nreq_f(nsel);
      mf = 0; mpact = prd_f(fsel, flen);
      mfull = full;
    end else begin
      if (mk % 2 == 1) mfull = full;
      mk++;
      if (mn == mnact - 1) begin mn = 0; mnact = nreq_f(nsel); end
      else mn++;
      if (mf == mpact - 1) begin mf = 0; mpact = prd_f(fsel, flen); end
      else mf++;
    end
    @(negedge clk);
    cmp_all();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sreset();
    srst = 1'b1;
    tick();
    srst = 1'b0;
  endtask

  task automatic t_async();
    repeat (3) @(negedge clk);
    ctx = "R1";
    chk("R1", "ref_en in reset", ref_en_o, 0);
    ctx = "R10";
    chk("R2", "div2 in reset", div2_o, 1);
    chk("R3", "div4 in reset", div4_o, 1);
    chk("R4", "divn in reset", divn_o, 1);
    chk("R6", "frame in reset", frame_o, 1);
    chk("R5", "core_en in reset", core_en_o, 1);
    mk = 0; mn = 0; mnact = 4; mf = 0; mpact = 127; mfull = 1'b0; mref = 1'b0;
    rst_ni = 1'b1;
    run(300);
  endtask

  task automatic t_sync();
    ctx = "R9";
    nsel = 4'd1; fsel = 4'd0; flen = 32'd10; full = 1'b0;
    srst = 1'b1; tick(); tick(); srst = 1'b0;
    run(64);
    run(7);
    nsel = 4'd2; flen = 32'd13; full = 1'b1;
    sreset();
    run(60);
  endtask

  task automatic t_codes();
    ctx = "R4";
    full = 1'b0;
    for (int c = 0; c < 16; c++) begin
      nsel = 4'(c);
      sreset();
      run(2 * nreq_f(4'(c)) + 3);
    end
  endtask

  task automatic t_nchg();
    ctx = "R7";
    nsel = 4'd1;
    sreset();
    run(5);
    nsel = 4'd4;
    run(150);
    nsel = 4'd0;
    run(41);
    nsel = 4'd2;
    run(80);
    nsel = 4'd15;
    run(9);
    nsel = 4'd0;
    run(2100);
  endtask

  task automatic t_frame();
    ctx = "R6";
    for (int s = 1; s <= 3; s++) begin
      fsel = 4'(s);
      sreset();
      run(2 * int'(prd_f(4'(s), 0)) + 4);
    end
    for (int s = 4; s <= 9; s++) begin
      fsel = 4'(s);
      sreset();
      run(300);
    end
    fsel = 4'd12; flen = 32'd0;
    sreset();
    run(20);
    fsel = 4'd0; flen = 32'd1;
    sreset();
    run(20);
    flen = 32'd3;
    run(20);
  endtask

  task automatic t_fchg();
    ctx = "R8";
    fsel = 4'd0; flen = 32'd20;
    sreset();
    run(7);
    flen = 32'd5;
    run(40);
    flen = 32'd33;
    run(3);
    fsel = 4'd1;
    run(300);
  endtask

  task automatic t_mode();
    ctx = "R5";
    full = 1'b1; nsel = 4'd0; fsel = 4'd0; flen = 32'd9;
    sreset();
    run(20);
    full = 1'b0;
    run(11);
    full = 1'b1;
    run(15);
    full = 1'b0;
    run(4);
    full = 1'b1;
    sreset();
    run(10);
  endtask

  initial begin
    t_async();
    t_sync();
    t_codes();
    t_nchg();
    t_frame();
    t_fchg();
    t_mode();
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    ntot++;
    nbad++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

endmodule